// File: doc/BRIEF.md
# Hash Engine Control Sequencer

This block is the control sequencer that sits beside a hash compression core. It reads a 32-bit mode word and decides when a block of processing begins. A block can begin on an explicit start strobe, automatically once a full block of sixteen input words has arrived, or on a write to input word 0. Each block's processing time is modelled by a down-counter whose length depends on the selected algorithm and on a short/long delay bit. The compression datapath itself is outside this block. Only the timing, the busy indication and the data-ready flag are produced here.

The data-ready flag follows reporting rules that depend on the start mode, a block-end reporting bit, and whether keyed (HMAC) hashing is selected. A dual-input-buffer bit allows the next block's words to be written while the current block is still running. A tamper-lock bit lets an external tamper signal freeze the engine until the cause is gone and an unlock strobe arrives. An always-on bit turns a start strobe into endless back-to-back dummy blocks, which can be used to add current draw while another engine is working.

Top module: `hash_ctl_seq`

## Requirements
- R1: After synchronous reset, `busy`, `data_rdy` and `locked` are all 0.
- R2: A block keeps `busy` high for exactly the latency selected by algorithm field `mode_word[11:8]` and delay bit `mode_word[4]`. The values are: code 0 (SHA-1) 85 or 209 cycles; code 1 (SHA-256) and code 4 (SHA-224) 72 or 194 cycles; code 2 (SHA-384) and code 3 (SHA-512) 88 or 209 cycles. The longer value applies when the delay bit is 1. Keyed codes 8 to 12 use the latency of their low three bits.
- R3: In start mode 0 (`mode_word[1:0]`=0), a block begins only on `start_pulse`. In start modes 0 and 1, `data_rdy` rises when every block ends.
- R4: In start mode 1, a block begins once all 16 distinct word indices have been written. Repeated writes to one index count once.
- R5: In start mode 2, an accepted write to index 0 begins a block. Writes to other indices do not.
- R6: In start mode 2 with the block-end bit `mode_word[7]` clear, `data_rdy` rises at the end of a block only if `last_blk` was high when that block began.
- R7: In start mode 2 with the block-end bit set and a plain algorithm (code below 5), `data_rdy` rises after every block.
- R8: In start mode 2 with the block-end bit set and a keyed algorithm (code 8 or above), `data_rdy` rises after every block except the one begun with `last_blk` high.
- R9: `data_rdy` clears when the next block begins.
- R10: With dual-buffer bit `mode_word[16]` set in start mode 2, a write to index 0 during a block is accepted and starts the next block right after the current one. With the bit clear, writes during a block are discarded.
- R11: With tamper-lock bit `mode_word[15]` set, `tamper_in` high locks the engine on the next cycle. The lock aborts any block, forces `busy` low and ignores starts. It clears only on `unlock_pulse` while `tamper_in` is low.
- R12: With the tamper-lock bit clear, `tamper_in` has no effect.
- R13: With always-on bit `mode_word[3]` set, `start_pulse` begins back-to-back dummy blocks that keep `busy` high without setting `data_rdy`. They stop at the end of the block during which the bit is cleared.
- R14: Start mode 3 is reserved and never begins a block unless the always-on bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | 32 | Mode word (fields listed in the requirements) |
| start_pulse | input | 1 | Start command strobe |
| unlock_pulse | input | 1 | Unlock command strobe |
| wr_en | input | 1 | Input-word write strobe |
| wr_idx | input | 4 | Index of the input word being written |
| tamper_in | input | 1 | Tamper event level |
| last_blk | input | 1 | Marks the block being started as the last of the message |
| busy | output | 1 | High while a block is being processed |
| data_rdy | output | 1 | Data-ready flag |
| locked | output | 1 | Tamper lock status |

## Verification
The latency is swept over every algorithm group and both delay settings in manual mode. This separates the three latency pairs and shows that the delay bit picks the long value. The start paths are then tried with distinct write patterns: duplicated indices against a full index set in automatic mode, and index 5 against index 0 in word-0 mode. These show what does and does not trigger a block. The reporting rules are tried over the combinations of block-end bit, plain versus keyed algorithm and last-block marking, which separates the three data-ready policies. Dual buffering, tamper lock with unlock ordering, the reserved start mode and always-on dummy runs each get directed sequences.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

    localparam int WORD_W = 32;
    localparam int NWORDS = 16;
    localparam int IDX_W  = $clog2(NWORDS);
    localparam int CNT_W  = 8;

    typedef enum logic [1:0] {
        SM_MANUAL = 2'd0,
        SM_AUTO   = 2'd1,
        SM_WORD0  = 2'd2,
        SM_RSVD   = 2'd3
    } smode_e;

    typedef struct packed {
        logic       dual;
        logic       tlock;
        logic [3:0] algo;
        logic       bpe;
        logic       dly;
        logic       aoe;
        smode_e     smod;
    } mode_t;

    function automatic mode_t decode_mode(input logic [WORD_W-1:0] w);
        mode_t m;
        m.smod  = smode_e'(w[1:0]);
        m.aoe   = w[3];
        m.dly   = w[4];
        m.bpe   = w[7];
        m.algo  = w[11:8];
        m.tlock = w[15];
        m.dual  = w[16];
        return m;
    endfunction

    // Per-block latency in cycles, picked by algorithm group and delay bit
    function automatic logic [CNT_W-1:0] block_latency(input logic [3:0] algo, input logic dly);
        logic [CNT_W-1:0] l;
        unique case (algo[2:0])
            3'd0:        l = dly ? 8'd209 : 8'd85;
            3'd2, 3'd3:  l = dly ? 8'd209 : 8'd88;
            default:     l = dly ? 8'd194 : 8'd72;
        endcase
        return l;
    endfunction

    function automatic logic is_keyed(input logic [3:0] algo);
        return algo[3];
    endfunction

endpackage

// File: rtl/hseq_latency.sv
module hseq_latency
    import hseq_pkg::*;
#(
    parameter int CW = CNT_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          load,
    input  logic [CW-1:0] lat,
    output logic          running,
    output logic          done
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= lat - ONE;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - ONE;
        end
    end

    assign done = running && (cnt == '0);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt < 8'd209));

endmodule

// File: rtl/hseq_words.sv
module hseq_words
    import hseq_pkg::*;
#(
    parameter int NW = NWORDS,
    parameter int IW = $clog2(NW)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          accept_ok,
    input  logic          consume,
    output logic          all_full,
    output logic          word0_pend
);
    logic [NW-1:0] mask, mask_n;
    logic          acc;

    assign acc = wr_en && accept_ok;

    always_comb begin
        mask_n = consume ? '0 : mask;
        if (acc) mask_n[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mask       <= '0;
            word0_pend <= 1'b0;
        end else begin
            mask <= mask_n;
            if (acc && (wr_idx == '0)) word0_pend <= 1'b1;
            else if (consume)          word0_pend <= 1'b0;
        end
    end

    assign all_full = &mask;

    assert_pend_from_write_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(word0_pend) |-> $past(wr_en && (wr_idx == '0)));

endmodule

// File: rtl/hseq_lock.sv
module hseq_lock (
    input  logic clk,
    input  logic rst,
    input  logic tlock_en,
    input  logic tamper,
    input  logic unlock,
    output logic lock_set,
    output logic locked
);
    assign lock_set = tlock_en && tamper;

    always_ff @(posedge clk) begin
        if (rst)                             locked <= 1'b0;
        else if (lock_set)                   locked <= 1'b1;
        else if (locked && unlock && !tamper) locked <= 1'b0;
    end

    assert_tamper_locks_R11: assert property (@(posedge clk) disable iff (rst)
        (tlock_en && tamper) |=> locked);

    assert_unlock_order_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($past(unlock) && !$past(tamper)));

endmodule

// File: rtl/hash_ctl_seq.sv
module hash_ctl_seq
    import hseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] mode_word,
    input  logic              start_pulse,
    input  logic              unlock_pulse,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              tamper_in,
    input  logic              last_blk,
    output logic              busy,
    output logic              data_rdy,
    output logic              locked
);
    mode_t m;
    assign m = decode_mode(mode_word);

    logic unused_mode_bits;
    assign unused_mode_bits = ^{mode_word[31:17], mode_word[14:12], mode_word[6:5], mode_word[2]};

    logic lock_set, is_locked, frozen;
    logic running, blk_done;
    logic all_full, word0_pend;
    logic idle_ok, accept_ok;
    logic start_real, start_dummy, cont_dummy, load;
    logic dummy_q, last_q, rdy_q, report;

    hseq_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .tlock_en (m.tlock),
        .tamper   (tamper_in),
        .unlock   (unlock_pulse),
        .lock_set (lock_set),
        .locked   (is_locked)
    );

    assign frozen  = is_locked || lock_set;
    assign idle_ok = !running && !frozen;

    assign accept_ok = !frozen && (!running || (m.dual && (m.smod == SM_WORD0)));

    always_comb begin
        start_real = 1'b0;
        if (idle_ok && !m.aoe) begin
            unique case (m.smod)
                SM_MANUAL: start_real = start_pulse;
                SM_AUTO:   start_real = all_full;
                SM_WORD0:  start_real = word0_pend;
                default:   start_real = 1'b0;
            endcase
        end
    end

    assign start_dummy = idle_ok && m.aoe && start_pulse;
    assign cont_dummy  = blk_done && dummy_q && m.aoe && !frozen;
    assign load        = start_real || start_dummy || cont_dummy;

    hseq_words u_words (
        .clk        (clk),
        .rst        (rst),
        .clr        (frozen),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .accept_ok  (accept_ok),
        .consume    (start_real),
        .all_full   (all_full),
        .word0_pend (word0_pend)
    );

    hseq_latency u_lat (
        .clk     (clk),
        .rst     (rst),
        .abort   (frozen),
        .load    (load),
        .lat     (block_latency(m.algo, m.dly)),
        .running (running),
        .done    (blk_done)
    );

    // Data-ready policy at block end
    always_comb begin
        report = 1'b0;
        if (blk_done && !dummy_q) begin
            if (m.smod != SM_WORD0) report = 1'b1;
            else if (!m.bpe)        report = last_q;
            else if (is_keyed(m.algo)) report = !last_q;
            else                    report = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frozen) begin
            dummy_q <= 1'b0;
            last_q  <= 1'b0;
            rdy_q   <= 1'b0;
        end else begin
            if (start_dummy)                 dummy_q <= 1'b1;
            else if (start_real)             dummy_q <= 1'b0;
            else if (blk_done && !cont_dummy) dummy_q <= 1'b0;

            if (start_real) last_q <= last_blk;

            if (load)        rdy_q <= 1'b0;
            else if (report) rdy_q <= 1'b1;
        end
    end

    assign busy     = running && !is_locked;
    assign data_rdy = rdy_q;
    assign locked   = is_locked;

    assert_rdy_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !data_rdy);

    assert_dummy_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        (dummy_q && busy) |-> !data_rdy);

    assert_rsvd_idle_R14: assert property (@(posedge clk) disable iff (rst)
        (!busy && (m.smod == SM_RSVD) && !m.aoe) |=> !busy);

    assert_tlock_off_R12: assert property (@(posedge clk) disable iff (rst)
        (!m.tlock && !locked) |=> !locked);

endmodule

// File: tb/hash_ctl_seq_bench.sv
module hash_ctl_seq_bench;
    import hseq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mode_word = 32'h0000_0100;
    logic        start_pulse = 1'b0, unlock_pulse = 1'b0, wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        tamper_in = 1'b0, last_blk = 1'b0;
    logic        busy, data_rdy, locked;

    int nchk = 0;
    int nfail = 0;
    int cyc_count = 0;

    always #2 clk = ~clk;

    hash_ctl_seq u_hash_ctl_seq (
        .clk(clk), .rst(rst), .mode_word(mode_word), .start_pulse(start_pulse),
        .unlock_pulse(unlock_pulse), .wr_en(wr_en), .wr_idx(wr_idx),
        .tamper_in(tamper_in), .last_blk(last_blk),
        .busy(busy), .data_rdy(data_rdy), .locked(locked)
    );

    typedef struct packed {
        logic [3:0] algo;
        logic       dly;
        logic [7:0] lat;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{4'd0, 1'b0, 8'd85},  '{4'd0, 1'b1, 8'd209},
        '{4'd1, 1'b0, 8'd72},  '{4'd1, 1'b1, 8'd194},
        '{4'd4, 1'b0, 8'd72},  '{4'd4, 1'b1, 8'd194},
        '{4'd2, 1'b0, 8'd88},  '{4'd2, 1'b1, 8'd209},
        '{4'd3, 1'b0, 8'd88},  '{4'd3, 1'b1, 8'd209}
    };

    function automatic logic [31:0] mk(input logic [1:0] smod, input logic aoe, input logic dly,
                                       input logic bpe, input logic [3:0] algo,
                                       input logic tlock, input logic dual);
        logic [31:0] w = '0;
        w[1:0] = smod; w[3] = aoe; w[4] = dly; w[7] = bpe;
        w[11:8] = algo; w[15] = tlock; w[16] = dual;
        return w;
    endfunction

    task automatic report_end();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_pulse = 1'b1; tick(1); start_pulse = 1'b0;
    endtask

    task automatic pulse_unlock();
        unlock_pulse = 1'b1; tick(1); unlock_pulse = 1'b0;
    endtask

    task automatic wr(input int idx);
        wr_en = 1'b1; wr_idx = 4'(idx); tick(1); wr_en = 1'b0;
    endtask

    // Waits for busy, then counts sampled busy cycles; ends on the negedge after it falls
    task automatic measure(output int cyc);
        int w = 0;
        while (!busy && w < 20) begin tick(1); w++; end
        cyc = 0;
        while (busy && cyc < 2000) begin cyc++; tick(1); end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc_count++;
            if (cyc_count > 150000) begin
                nfail++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc_count);
                report_end();
            end
        end
    end

    initial begin
        int n;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 data_rdy", data_rdy, 0);
        check("R1 locked", locked, 0);

        // R2/R3 latency sweep in manual mode; R9 clear at next start
        for (int i = 0; i < 10; i++) begin
            mode_word = mk(2'd0, 1'b0, VEC[i].dly, 1'b0, VEC[i].algo, 1'b0, 1'b0);
            tick(1);
            pulse_start();
            if (i > 0) check("R9 rdy cleared on start", data_rdy, 0);
            measure(n);
            check("R2 latency", n, int'(VEC[i].lat));
            check("R3 rdy after block", data_rdy, 1);
        end

        // R3 no start without strobe in manual mode
        tick(5);
        check("R3 idle without strobe", busy, 0);

        // R4 automatic mode
        mode_word = mk(2'd1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) wr(3);
        tick(3);
        check("R4 duplicates do not start", busy, 0);
        for (int i = 0; i < 15; i++) wr(i);
        tick(3);
        check("R4 fifteen words do not start", busy, 0);
        wr(15);
        measure(n);
        check("R4 start on full block", n, 85);

        // R5/R6 word-0 mode, block-end bit clear
        mode_word = mk(2'd2, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0);
        last_blk = 1'b1;
        wr(5);
        tick(3);
        check("R5 index 5 no start", busy, 0);
        wr(0);
        measure(n);
        check("R5 index 0 starts", n, 72);
        check("R6 rdy on last block", data_rdy, 1);
        last_blk = 1'b0;
        wr(0);
        measure(n);
        check("R6 no rdy on middle block", data_rdy, 0);

        // R7 plain, block-end bit set
        mode_word = mk(2'd2, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0);
        wr(0);
        measure(n);
        check("R7 rdy on middle block", data_rdy, 1);

        // R8 keyed, block-end bit set
        mode_word = mk(2'd2, 1'b0, 1'b0, 1'b1, 4'd9, 1'b0, 1'b0);
        wr(0);
        measure(n);
        check("R8 keyed latency", n, 72);
        check("R8 rdy on non-last block", data_rdy, 1);
        last_blk = 1'b1;
        wr(0);
        measure(n);
        check("R8 no rdy on last block", data_rdy, 0);
        last_blk = 1'b0;

        // R10 dual buffer on
        mode_word = mk(2'd2, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1);
        wr(0);
        tick(5);
        wr(0);
        measure(n);
        measure(n);
        check("R10 queued block runs", n, 72);

        // R10 dual buffer off
        mode_word = mk(2'd2, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0);
        wr(0);
        tick(5);
        wr(0);
        measure(n);
        tick(5);
        check("R10 write during block dropped", busy, 0);

        // R14 reserved start mode
        mode_word = mk(2'd3, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0);
        pulse_start();
        wr(0);
        tick(5);
        check("R14 reserved mode no start", busy, 0);

        // R11 tamper lock
        mode_word = mk(2'd0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1, 1'b0);
        pulse_start();
        tick(10);
        tamper_in = 1'b1;
        tick(1);
        check("R11 locked", locked, 1);
        check("R11 busy forced low", busy, 0);
        pulse_start();
        tick(2);
        check("R11 start ignored", busy, 0);
        pulse_unlock();
        check("R11 unlock blocked by tamper", locked, 1);
        tamper_in = 1'b0;
        tick(2);
        check("R11 stays locked without strobe", locked, 1);
        pulse_unlock();
        check("R11 unlocked", locked, 0);
        pulse_start();
        measure(n);
        check("R11 runs after unlock", n, 72);

        // R12 tamper ignored when lock bit clear
        mode_word = mk(2'd0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0);
        pulse_start();
        tick(5);
        tamper_in = 1'b1;
        tick(3);
        check("R12 not locked", locked, 0);
        check("R12 still busy", busy, 1);
        measure(n);
        tamper_in = 1'b0;
        check("R12 block completes", data_rdy, 1);

        // R13 always-on dummy blocks
        mode_word = mk(2'd0, 1'b1, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0);
        pulse_start();
        begin
            int hi = 0;
            int rdy = 0;
            for (int i = 0; i < 300; i++) begin
                if (busy) hi++;
                if (data_rdy) rdy++;
                tick(1);
            end
            check("R13 continuous busy", hi, 300);
            check("R13 no data_rdy", rdy, 0);
        end
        mode_word = mk(2'd0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0);
        measure(n);
        check("R13 stops within one block", (n <= 72) ? 1 : 0, 1);
        tick(5);
        check("R13 idle after stop", busy, 0);
        check("R13 no rdy after stop", data_rdy, 0);

        report_end();
    end

endmodule